// File: doc/BRIEF.md
# Frame CRC-16 Checking Engine

This block computes a running 16-bit frame check sequence over bytes that software or a receive path hands to it one at a time. A control write with the restart bit set returns the engine to its seed value and clears the count of accepted inputs. Each accepted input value contributes its low byte. The byte is folded into the CRC in a single clock, least-significant bit first. The polynomial is x^16+x^12+x^5+1 in reflected form (0x8408), the seed is 0xFFFF and the result is shown inverted.

Data enters on a valid/ready stream. The engine never applies back-pressure: `in_ready` is high in every cycle after reset, so any cycle with `in_valid` high delivers exactly one value. The control port and the two status outputs are plain pins. The status outputs are the CRC of everything folded since the last restart and a 12-bit saturating input count. Both are driven straight from registers and need no trigger. At start-up, software can run a fixed four-byte self-test and compare both status values against known constants.

Top module: `crc16_frame_engine`

## Requirements
- R1: After the asynchronous active-low reset, `crc_value` reads 0x0000 and `in_count` reads 0.
- R2: A `ctl_wr` cycle with `ctl_wdata` bit 15 set makes `crc_value` read 0x0000 and `in_count` read 0 after that clock edge. A `ctl_wr` cycle with bit 15 clear changes nothing, and `ctl_wdata` bits 14:0 are ignored.
- R3: `in_ready` is 1 in every cycle out of reset. Each cycle with `in_valid` high folds `in_data` bits 7:0 into the CRC, LSB first, using the reflected polynomial 0x8408 and seed 0xFFFF. `crc_value` is the bitwise inverse of the internal state.
- R4: `in_data` bits 11:8 have no effect on `crc_value`.
- R5: Each accepted input raises `in_count` by one, visible after the clock edge that accepted it.
- R6: `in_count` saturates at 0xFFF; accepted inputs still update the CRC once it has saturated.
- R7: Without an accepted input or a restart write, `crc_value` and `in_count` hold their values.
- R8: After a restart, feeding 0xCC, 0xF5, 0xF1 and 0xA7 in that order gives `in_count` = 4 and `crc_value` = 0x51DF.
- R9: A restart write and an accepted input in the same cycle result in the restart: the input is discarded, `crc_value` = 0x0000 and `in_count` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write data; bit 15 requests a restart |
| in_valid | input | 1 | Input value present on `in_data` |
| in_ready | output | 1 | Engine accepts input (always 1 out of reset) |
| in_data | input | 12 | Input value; bits 7:0 are folded |
| crc_value | output | 16 | Inverted CRC of all bytes folded since restart |
| in_count | output | 12 | Saturating count of accepted inputs |

## Verification
The fixed four-byte self-test pins down the exact polynomial, bit order, seed and output inversion together, because a wrong choice in any one of them gives a different result. Random bytes arrive with gaps and occasional control writes, and they are compared each cycle against a bit-serial model. This separates per-cycle acceptance from idle holding and shows that control writes with the restart bit clear are harmless. Directed cases cover the following:
- the same byte sent with different upper nibbles, to show those bits are ignored;
- a restart colliding with data;
- more than 4095 inputs, to show the count stops at its ceiling while the CRC keeps moving.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int unsigned CRC_W  = 16;
  localparam int unsigned BYTE_W = 8;

  typedef logic [CRC_W-1:0] crc_t;

  typedef struct packed {
    logic restart;
    logic take;
  } crc_cmd_t;
endpackage

// File: rtl/crc_byte_fold.sv
module crc_byte_fold
  import crc16_pkg::*;
#(
  parameter crc_t POLY = 16'h8408
) (
  input  crc_t              cur,
  input  logic [BYTE_W-1:0] byte_in,
  output crc_t              nxt
);
  localparam int unsigned PAD_W = CRC_W - BYTE_W;

  crc_t stage [0:BYTE_W];

  assign stage[0] = cur ^ {{PAD_W{1'b0}}, byte_in};

  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    assign stage[i+1] = stage[i][0] ? ((stage[i] >> 1) ^ POLY) : (stage[i] >> 1);
  end

  assign nxt = stage[BYTE_W];
endmodule

// File: rtl/crc_state_reg.sv
module crc_state_reg
  import crc16_pkg::*;
#(
  parameter crc_t SEED = 16'hFFFF
) (
  input  logic     clk,
  input  logic     rst_n,
  input  crc_cmd_t cmd,
  input  crc_t     nxt,
  output crc_t     state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           state <= SEED;
    else if (cmd.restart) state <= SEED;
    else if (cmd.take)    state <= nxt;
  end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   count <= '0;
    else if (clear)               count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/crc16_frame_engine.sv
module crc16_frame_engine
  import crc16_pkg::*;
#(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned IN_W        = 12,
  parameter int unsigned CTL_W       = 16,
  parameter int unsigned RESTART_BIT = 15,
  parameter crc_t        POLY        = 16'h8408,
  parameter crc_t        SEED        = 16'hFFFF,
  parameter crc_t        XOR_OUT     = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic [CRC_W-1:0] crc_value,
  output logic [CNT_W-1:0] in_count
);
  crc_cmd_t cmd;
  crc_t     folded;
  crc_t     state;
  logic     unused_bits;

  assign in_ready    = rst_n;
  assign cmd.restart = ctl_wr & ctl_wdata[RESTART_BIT];
  assign cmd.take    = in_valid & in_ready;

  crc_byte_fold #(.POLY(POLY)) fold_i (
    .cur     (state),
    .byte_in (in_data[BYTE_W-1:0]),
    .nxt     (folded)
  );

  crc_state_reg #(.SEED(SEED)) state_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (cmd),
    .nxt   (folded),
    .state (state)
  );

  sat_counter #(.W(CNT_W)) count_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (cmd.restart),
    .inc   (cmd.take),
    .count (in_count)
  );

  assign crc_value   = state ^ XOR_OUT;
  assign unused_bits = ^{ctl_wdata[RESTART_BIT-1:0], in_data[IN_W-1:BYTE_W]};
endmodule

// File: rtl/crc16_frame_engine_chk.sv
module crc16_frame_engine_chk #(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned IN_W        = 12,
  parameter int unsigned CTL_W       = 16,
  parameter int unsigned RESTART_BIT = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic [CTL_W-1:0] ctl_wdata,
  input logic             in_valid,
  input logic             in_ready,
  input logic [IN_W-1:0]  in_data,
  input logic [15:0]      crc_value,
  input logic [CNT_W-1:0] in_count
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic rs;
  assign rs = ctl_wr && ctl_wdata[RESTART_BIT];

  // R2 and R9: restart wins over any data in the same cycle
  a_r2_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rs |=> (in_count == '0 && crc_value == 16'h0000));

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !rs && in_count != TOP) |=> in_count == $past(in_count) + 1'b1);

  a_r6_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (in_count == TOP && !rs) |=> in_count == TOP);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !rs) |=> ($stable(in_count) && $stable(crc_value)));
endmodule

bind crc16_frame_engine crc16_frame_engine_chk #(
  .CNT_W(CNT_W), .IN_W(IN_W), .CTL_W(CTL_W), .RESTART_BIT(RESTART_BIT)
) chk_i (.*);

// File: tb/crc16_frame_engine_tb_top.sv
module crc16_frame_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_data = '0;
  logic [15:0] crc_value;
  logic [11:0] in_count;

  int total = 0;
  int bad = 0;
  logic [15:0] m_state;
  logic [11:0] m_cnt;

  always #5 clk = ~clk;

  crc16_frame_engine dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .crc_value(crc_value), .in_count(in_count)
  );

  function automatic logic [15:0] ref_fold(input logic [15:0] s, input logic [7:0] b);
    logic [15:0] c;
    c = s;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ 16'h8408;
      else             c = c >> 1;
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, model update at posedge, sample at the following negedge
  task automatic cyc(input logic cw, input logic [15:0] cd, input logic v, input logic [11:0] d);
    ctl_wr = cw; ctl_wdata = cd; in_valid = v; in_data = d;
    @(posedge clk);
    if (cw && cd[15]) begin
      m_state = 16'hFFFF; m_cnt = '0;
    end else if (v) begin
      m_state = ref_fold(m_state, d[7:0]);
      if (m_cnt != 12'hFFF) m_cnt = m_cnt + 1'b1;
    end
    @(negedge clk);
    ctl_wr = 1'b0; in_valid = 1'b0;
  endtask

  task automatic compare(input string req);
    check({req, " crc"}, {16'h0, crc_value}, {16'h0, m_state ^ 16'hFFFF});
    check({req, " count"}, {20'h0, in_count}, {20'h0, m_cnt});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] crc_a;
    void'($urandom(32'h5EED_0C2C));
    m_state = 16'hFFFF; m_cnt = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 crc", {16'h0, crc_value}, 32'h0);
    check("R1 count", {20'h0, in_count}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 ready", {31'h0, in_ready}, 32'h1);

    // R8: self-test vector
    cyc(1'b1, 16'h8000, 1'b0, 12'h0);
    cyc(1'b0, 16'h0, 1'b1, 12'h0CC);
    cyc(1'b0, 16'h0, 1'b1, 12'h0F5);
    cyc(1'b0, 16'h0, 1'b1, 12'h0F1);
    cyc(1'b0, 16'h0, 1'b1, 12'h0A7);
    check("R8 count", {20'h0, in_count}, 32'h4);
    check("R8 crc", {16'h0, crc_value}, 32'h51DF);

    // R2: control write with bit 15 clear, other bits set, changes nothing
    cyc(1'b1, 16'h7FFF, 1'b0, 12'h0);
    check("R2 noop count", {20'h0, in_count}, 32'h4);
    check("R2 noop crc", {16'h0, crc_value}, 32'h51DF);

    // R7: idle cycles hold
    repeat (3) cyc(1'b0, 16'h0, 1'b0, 12'hABC);
    check("R7 hold crc", {16'h0, crc_value}, 32'h51DF);

    // R4: upper nibble ignored
    cyc(1'b1, 16'h8000, 1'b0, 12'h0);
    cyc(1'b0, 16'h0, 1'b1, 12'h05A);
    crc_a = crc_value;
    cyc(1'b1, 16'h8000, 1'b0, 12'h0);
    cyc(1'b0, 16'h0, 1'b1, 12'hF5A);
    check("R4 upper bits", {16'h0, crc_value}, {16'h0, crc_a});
    compare("R4");

    // R9: restart collides with data
    cyc(1'b0, 16'h0, 1'b1, 12'h033);
    cyc(1'b1, 16'hFFFF, 1'b1, 12'h077);
    check("R9 crc", {16'h0, crc_value}, 32'h0);
    check("R9 count", {20'h0, in_count}, 32'h0);

    // R3 R5 R7 R2: constrained random
    for (int n = 0; n < 400; n++) begin
      logic cw;
      logic [15:0] cd;
      cw = ($urandom % 20) == 0;
      cd = $urandom;
      cyc(cw, cd, ($urandom % 10) < 7, 12'($urandom));
      compare("R3 R5 random");
    end

    // R6: saturation
    cyc(1'b1, 16'h8000, 1'b0, 12'h0);
    for (int n = 0; n < 4100; n++) cyc(1'b0, 16'h0, 1'b1, 12'($urandom));
    check("R6 sat count", {20'h0, in_count}, 32'hFFF);
    compare("R6 after saturation");
    crc_a = crc_value;
    cyc(1'b0, 16'h0, 1'b1, 12'h0C3);
    check("R6 count stays", {20'h0, in_count}, 32'hFFF);
    compare("R6 crc moves");

    // R2: restart after saturation
    cyc(1'b1, 16'h8000, 1'b0, 12'h0);
    check("R2 restart count", {20'h0, in_count}, 32'h0);
    check("R2 restart crc", {16'h0, crc_value}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule